// File: doc/BRIEF.md
# Channel Reconfiguration Request Arbiter

This block sits between a set of requestors, each of which may need a transceiver channel retuned, and a single downstream sequencer that performs the retuning. Every requestor drives a level request together with the channel it wants changed and a two-bit target mode. The arbiter picks one pending request, returns an acknowledge/busy bit to that requestor alone, and hands the chosen channel and mode to the sequencer with a one-cycle start pulse. From then on it serves nobody else until the sequencer returns a done pulse. A requestor is expected to withdraw its request as soon as it sees its acknowledge bit.

Selection is round-robin. The search starts at the requestor after the last one granted and wraps around, so a requestor that keeps asking cannot shut out the others. Requests are levels, not captured events: a request withdrawn before the arbiter is free again is never served.

The control is a three-state machine. `ST_IDLE` waits for any request; the transition T_GRANT (any request present) moves to `ST_LAUNCH`, registering the winner's channel, mode and acknowledge bit. `ST_LAUNCH` lasts one cycle, drives the start pulse and always takes T_ISSUE to `ST_HOLD`. `ST_HOLD` loops until done is sampled, then takes T_RELEASE back to `ST_IDLE`, clearing the acknowledge bit on the same edge.

Top module: `reconf_arbiter`

## Requirements
- R1: While reset is asserted and on leaving it, `ack_o`, `seq_start_o`, `seq_chan_o` and `seq_mode_o` are all zero.
- R2: When the arbiter is idle and at least one request is high at a clock edge, the acknowledge bit of an asserted requestor is high right after that edge; no acknowledge bit rises for a requestor whose request was low.
- R3: At most one bit of `ack_o` is high in any cycle.
- R4: The winner is the first asserted request found by counting upward from the last granted index plus one, wrapping from NUM_REQ-1 to 0; after reset the search starts at index 0.
- R5: `seq_chan_o` and `seq_mode_o` carry the winner's channel (bits i*CH_W and up of `req_chan_i`) and mode (bits 2i+1:2i of `req_mode_i`) unchanged, captured on the grant edge and held until the grant is released; the mode codes are 00 for 1G data, 01 for 10G data, 10 for auto-negotiation and 11 for link training.
- R6: `seq_start_o` is high for exactly one cycle per grant, in the first cycle the acknowledge bit is high.
- R7: Once granted, the acknowledge bit stays high until `seq_done_i` is sampled in the hold state and falls on that same edge; with the done pulse D cycles after start, the acknowledge bit is high for D+1 cycles, and between two grants it is low for at least one cycle.
- R8: While a grant is held, other requests get no acknowledge; a request withdrawn before the grant is released is never served.
- R9: A done pulse while idle or in the start cycle has no effect: no grant is created and a held grant is not released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_i | input | NUM_REQ | Level request, one bit per requestor |
| req_chan_i | input | NUM_REQ*CH_W | Requested channel per requestor, requestor i in bits i*CH_W and up |
| req_mode_i | input | NUM_REQ*2 | Target mode per requestor, requestor i in bits 2i+1:2i |
| seq_done_i | input | 1 | One-cycle completion pulse from the sequencer |
| ack_o | output | NUM_REQ | Acknowledge/busy, one-hot to the granted requestor |
| seq_start_o | output | 1 | One-cycle pulse starting the sequencer |
| seq_chan_o | output | CH_W | Channel handed to the sequencer |
| seq_mode_o | output | 2 | Mode handed to the sequencer |

## Verification
The bench builds the block with NUM_REQ=4 and CH_W=4. Four requestors make the wrap of the round-robin pointer reachable within a handful of grants and let every mode code travel through a single burst, while four channel bits give each requestor a distinct channel so a mis-steered multiplexer shows on the sequencer side. The sequencer latency is varied by the bench, from one cycle up to ten, so that both back-to-back grants and long holds with competing and withdrawn requests are covered.

// File: rtl/reconf_arb_pkg.sv
package reconf_arb_pkg;

    localparam int MODE_W = 2;

    typedef enum logic [MODE_W-1:0] {
        MODE_DATA_1G  = 2'b00,
        MODE_DATA_10G = 2'b01,
        MODE_AUTONEG  = 2'b10,
        MODE_LINKTRN  = 2'b11
    } reconf_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'b00,
        ST_LAUNCH = 2'b01,
        ST_HOLD   = 2'b10
    } arb_state_e;

endpackage

// File: rtl/reconf_rr_pick.sv
module reconf_rr_pick #(
    parameter int NUM_REQ = 4,
    parameter int IDX_W   = 2
) (
    input  logic [NUM_REQ-1:0] req_i,
    input  logic [IDX_W-1:0]   last_i,
    output logic               any_o,
    output logic [IDX_W-1:0]   win_o,
    output logic [NUM_REQ-1:0] win_oh_o
);

    logic             any;
    logic [IDX_W-1:0] win;
    int               idx;

    // Search upward from the slot after the last winner, wrapping around.
    always_comb begin
        any = 1'b0;
        win = '0;
        idx = 0;
        for (int k = 1; k <= NUM_REQ; k++) begin
            idx = (int'(last_i) + k) % NUM_REQ;
            if (!any && req_i[idx]) begin
                any = 1'b1;
                win = IDX_W'(idx);
            end
        end
    end

    for (genvar g = 0; g < NUM_REQ; g++) begin : g_oh
        assign win_oh_o[g] = any && (win == IDX_W'(g));
    end

    assign any_o = any;
    assign win_o = win;

endmodule

// File: rtl/reconf_req_mux.sv
module reconf_req_mux #(
    parameter int NUM_REQ = 4,
    parameter int CH_W    = 4,
    parameter int MODE_W  = 2
) (
    input  logic [NUM_REQ*CH_W-1:0]   chan_flat_i,
    input  logic [NUM_REQ*MODE_W-1:0] mode_flat_i,
    input  logic [NUM_REQ-1:0]        sel_oh_i,
    output logic [CH_W-1:0]           chan_o,
    output logic [MODE_W-1:0]         mode_o
);

    logic [CH_W-1:0]   chan_masked [NUM_REQ];
    logic [MODE_W-1:0] mode_masked [NUM_REQ];

    // AND-OR selection: each slice is gated by its one-hot select bit.
    for (genvar g = 0; g < NUM_REQ; g++) begin : g_slice
        assign chan_masked[g] = sel_oh_i[g] ? chan_flat_i[g*CH_W +: CH_W]     : '0;
        assign mode_masked[g] = sel_oh_i[g] ? mode_flat_i[g*MODE_W +: MODE_W] : '0;
    end

    always_comb begin
        chan_o = '0;
        mode_o = '0;
        for (int i = 0; i < NUM_REQ; i++) begin
            chan_o = chan_o | chan_masked[i];
            mode_o = mode_o | mode_masked[i];
        end
    end

endmodule

// File: rtl/reconf_arbiter.sv
module reconf_arbiter
    import reconf_arb_pkg::*;
#(
    parameter int NUM_REQ = 4,
    parameter int CH_W    = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NUM_REQ-1:0]        req_i,
    input  logic [NUM_REQ*CH_W-1:0]   req_chan_i,
    input  logic [NUM_REQ*MODE_W-1:0] req_mode_i,
    input  logic                      seq_done_i,
    output logic [NUM_REQ-1:0]        ack_o,
    output logic                      seq_start_o,
    output logic [CH_W-1:0]           seq_chan_o,
    output logic [MODE_W-1:0]         seq_mode_o
);

    localparam int IDX_W = (NUM_REQ > 1) ? $clog2(NUM_REQ) : 1;
    localparam logic [IDX_W-1:0] LAST_RST = IDX_W'(NUM_REQ - 1);

    arb_state_e         state_q, state_d;
    logic [IDX_W-1:0]   last_q;
    logic               pick_any;
    logic [IDX_W-1:0]   pick_idx;
    logic [NUM_REQ-1:0] pick_oh;
    logic [CH_W-1:0]    mux_chan;
    logic [MODE_W-1:0]  mux_mode;

    reconf_rr_pick #(
        .NUM_REQ (NUM_REQ),
        .IDX_W   (IDX_W)
    ) u_pick (
        .req_i    (req_i),
        .last_i   (last_q),
        .any_o    (pick_any),
        .win_o    (pick_idx),
        .win_oh_o (pick_oh)
    );

    reconf_req_mux #(
        .NUM_REQ (NUM_REQ),
        .CH_W    (CH_W),
        .MODE_W  (MODE_W)
    ) u_mux (
        .chan_flat_i (req_chan_i),
        .mode_flat_i (req_mode_i),
        .sel_oh_i    (pick_oh),
        .chan_o      (mux_chan),
        .mode_o      (mux_mode)
    );

    // Next-state logic: T_GRANT, T_ISSUE, T_RELEASE.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (pick_any)   state_d = ST_LAUNCH;
            ST_LAUNCH:                 state_d = ST_HOLD;
            ST_HOLD:   if (seq_done_i) state_d = ST_IDLE;
            default:                   state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Registered outputs and round-robin pointer.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ack_o       <= '0;
            seq_start_o <= 1'b0;
            seq_chan_o  <= '0;
            seq_mode_o  <= '0;
            last_q      <= LAST_RST;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (pick_any) begin
                        ack_o       <= pick_oh;
                        seq_start_o <= 1'b1;
                        seq_chan_o  <= mux_chan;
                        seq_mode_o  <= mux_mode;
                        last_q      <= pick_idx;
                    end
                end
                ST_LAUNCH: begin
                    seq_start_o <= 1'b0;
                end
                ST_HOLD: begin
                    if (seq_done_i) begin
                        ack_o <= '0;
                    end
                end
                default: begin
                    ack_o       <= '0;
                    seq_start_o <= 1'b0;
                end
            endcase
        end
    end

endmodule

// File: rtl/reconf_arbiter_chk.sv
module reconf_arbiter_chk #(
    parameter int NUM_REQ = 4,
    parameter int CH_W    = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic [NUM_REQ-1:0] req_i,
    input logic               seq_done_i,
    input logic [NUM_REQ-1:0] ack_o,
    input logic               seq_start_o,
    input logic [CH_W-1:0]    seq_chan_o,
    input logic [1:0]         seq_mode_o
);

    a_r3_ack_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ack_o));

    a_r2_grant_to_requestor: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(|ack_o) |-> (($past(req_i) & ack_o) != '0));

    a_r5_payload_held: assert property (@(posedge clk) disable iff (!rst_n)
        ((|ack_o) && !seq_start_o) |=> ($stable(seq_chan_o) && $stable(seq_mode_o)));

    a_r6_start_with_ack: assert property (@(posedge clk) disable iff (!rst_n)
        seq_start_o |-> ($rose(|ack_o)));

    a_r6_start_single: assert property (@(posedge clk) disable iff (!rst_n)
        seq_start_o |=> !seq_start_o);

    a_r7_hold_without_done: assert property (@(posedge clk) disable iff (!rst_n)
        ((|ack_o) && !seq_done_i) |=> $stable(ack_o));

    a_r7_release_on_done: assert property (@(posedge clk) disable iff (!rst_n)
        ((|ack_o) && !seq_start_o && seq_done_i) |=> (ack_o == '0));

    a_r9_launch_ignores_done: assert property (@(posedge clk) disable iff (!rst_n)
        seq_start_o |=> $stable(ack_o));

endmodule

bind reconf_arbiter reconf_arbiter_chk #(
    .NUM_REQ (NUM_REQ),
    .CH_W    (CH_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_i       (req_i),
    .seq_done_i  (seq_done_i),
    .ack_o       (ack_o),
    .seq_start_o (seq_start_o),
    .seq_chan_o  (seq_chan_o),
    .seq_mode_o  (seq_mode_o)
);

// File: tb/reconf_arbiter_bench.sv
`timescale 1ns/1ps
module reconf_arbiter_bench;

    localparam int N  = 4;
    localparam int CW = 4;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [N-1:0]  req;
    logic [N*CW-1:0] rchan;
    logic [N*2-1:0]  rmode;
    logic          done;
    logic [N-1:0]  ack;
    logic          start;
    logic [CW-1:0] schan;
    logic [1:0]    smode;

    always #2 clk = ~clk;

    reconf_arbiter #(.NUM_REQ(N), .CH_W(CW)) u_reconf_arbiter (
        .clk(clk), .rst_n(rst_n), .req_i(req), .req_chan_i(rchan),
        .req_mode_i(rmode), .seq_done_i(done), .ack_o(ack),
        .seq_start_o(start), .seq_chan_o(schan), .seq_mode_o(smode)
    );

    int total = 0;
    int bad   = 0;

    // Behavioural reference: 0 idle, 1 start cycle, 2 holding.
    int m_st = 0, m_last = N - 1, m_ack = -1, m_chan = 0, m_mode = 0;
    bit m_start = 0;

    int  seq_lat = 1, cnt = 0;
    bit  early_done = 0, stray_done = 0;
    int  gnt_log[$];
    int  ack_len = 0, last_len = 0, gap = 0, min_gap = 1000;
    bit  seen_grant = 0;
    int  cyc = 0;

    task automatic chk(bit ok, string tag, string what, int act, int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            m_st = 0; m_last = N - 1; m_ack = -1; m_chan = 0; m_mode = 0; m_start = 0;
        end else if (m_st == 0) begin
            for (int k = 1; k <= N; k++) begin
                int j;
                j = (m_last + k) % N;
                if (m_st == 0 && req[j]) begin
                    m_ack = j; m_last = j; m_start = 1; m_st = 1;
                    m_chan = int'(rchan[j*CW +: CW]);
                    m_mode = int'(rmode[j*2 +: 2]);
                end
            end
        end else if (m_st == 1) begin
            m_start = 0; m_st = 2;
        end else if (done) begin
            m_ack = -1; m_st = 0;
        end
    end

    // Per-cycle compare, requestor withdrawal and sequencer stand-in.
    always @(negedge clk) begin
        if (rst_n) begin
            int exp_ack;
            exp_ack = (m_ack < 0) ? 0 : (1 << m_ack);
            chk(int'(ack) == exp_ack, "R4", "ack", int'(ack), exp_ack);
            chk($countones(ack) <= 1, "R3", "ack ones", $countones(ack), 1);
            chk(start == m_start, "R6", "start", int'(start), int'(m_start));
            chk(int'(schan) == m_chan, "R5", "chan", int'(schan), m_chan);
            chk(int'(smode) == m_mode, "R5", "mode", int'(smode), m_mode);
            req = req & ~ack;
            if (start) begin
                for (int i = 0; i < N; i++) if (ack[i]) gnt_log.push_back(i);
            end
            if (|ack) begin
                if (ack_len == 0 && seen_grant && gap < min_gap) min_gap = gap;
                ack_len++; gap = 0; seen_grant = 1;
            end else begin
                if (ack_len > 0) last_len = ack_len;
                ack_len = 0; gap++;
            end
            done = stray_done;
            if (cnt == 1) done = 1'b1;
            if (cnt > 0) cnt--;
            if (start) begin
                cnt = seq_lat;
                if (early_done) done = 1'b1;
            end
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            total++; bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic set_req(int i, int ch, int md);
        req[i] = 1'b1;
        rchan[i*CW +: CW] = CW'(ch);
        rmode[i*2 +: 2]   = 2'(md);
    endtask

    task automatic wait_idle();
        do @(negedge clk); while (req != 0 || ack != 0 || cnt != 0);
        @(negedge clk);
    endtask

    task automatic expect_log(string tag, int e0, int e1, int e2, int e3, int n);
        int e[4];
        e = '{e0, e1, e2, e3};
        chk(gnt_log.size() == n, tag, "grant count", gnt_log.size(), n);
        for (int i = 0; i < n && i < gnt_log.size(); i++)
            chk(gnt_log[i] == e[i], tag, "grant order", gnt_log[i], e[i]);
    endtask

    initial begin
        rst_n = 1'b0; req = '0; rchan = '0; rmode = '0; done = 1'b0;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(ack == 0,   "R1", "ack",   int'(ack), 0);
        chk(start == 0, "R1", "start", int'(start), 0);
        chk(schan == 0, "R1", "chan",  int'(schan), 0);
        chk(smode == 0, "R1", "mode",  int'(smode), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(ack == 0, "R1", "ack after release", int'(ack), 0);

        // R2: single request, one-edge latency, payload routed
        #1 set_req(1, 5, 1);
        @(negedge clk);
        chk(ack == 4'b0010, "R2", "ack latency", int'(ack), 2);
        chk(schan == 5 && smode == 1, "R5", "chan/mode", int'({schan, smode}), (5 << 2) | 1);
        wait_idle();

        // R4: all four at once after last=1, all mode codes
        gnt_log.delete();
        #1 set_req(0, 9, 0); set_req(1, 3, 1); set_req(2, 12, 2); set_req(3, 6, 3);
        wait_idle();
        expect_log("R4", 2, 3, 0, 1, 4);
        chk(min_gap >= 1, "R7", "gap between grants", min_gap, 1);

        // R4: wrap with two requestors after last=1
        gnt_log.delete();
        #1 set_req(0, 1, 2); set_req(3, 2, 3);
        wait_idle();
        expect_log("R4", 3, 0, 0, 0, 2);

        // R7: hold length equals latency plus one
        seq_lat = 4;
        #1 set_req(2, 7, 1);
        wait_idle();
        chk(last_len == 5, "R7", "ack length", last_len, 5);

        // R8: competing request withdrawn during a long hold
        seq_lat = 10;
        gnt_log.delete();
        #1 set_req(0, 4, 0);
        repeat (2) @(negedge clk);
        #1 set_req(3, 8, 2);
        repeat (3) @(negedge clk);
        chk(ack == 4'b0001, "R8", "ack while busy", int'(ack), 1);
        #1 req[3] = 1'b0;
        wait_idle();
        repeat (3) @(negedge clk);
        expect_log("R8", 0, 0, 0, 0, 1);
        chk(ack == 0, "R8", "withdrawn not served", int'(ack), 0);

        // R9: done while idle creates nothing
        #1 stray_done = 1'b1;
        @(negedge clk);
        #1 stray_done = 1'b0;
        @(negedge clk);
        chk(ack == 0 && start == 0, "R9", "idle done", int'({ack, start}), 0);

        // R9: done in the start cycle does not release
        seq_lat = 3; early_done = 1'b1;
        #1 set_req(1, 10, 3);
        @(negedge clk);
        #1 early_done = 1'b0;
        @(negedge clk);
        chk(ack == 4'b0010, "R9", "launch done ignored", int'(ack), 2);
        wait_idle();
        chk(last_len == 4, "R7", "ack length after early done", last_len, 4);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule